// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a 32-bit combinational arithmetic/logic unit assembled from identical one-bit slices joined by a ripple carry. Each slice works out the AND, the OR and the full-adder sum of its two operand bits at the same time. A four-way selector then picks one of these three, or a fourth input called "less", as the slice's result bit. Every slice gets the same 4-bit operation code. Bit 3 inverts the A operand and bit 2 inverts the B operand. Bit 2 also drives the carry into the lowest slice, so a subtraction takes the form a + ~b + 1. Bits 1:0 choose the result source: 00 selects AND, 01 OR, 10 sum and 11 less.

The topmost slice also produces a signed overflow flag and a "set" bit. The set bit is the subtraction sign corrected by the overflow. It feeds the less input of the lowest slice, and every other slice has its less input held at 0, which is how set-on-less-than is built. NOR needs no gate of its own: it is the AND of the inverted operands. A zero flag is raised when every result bit is clear, so a subtract followed by a look at that flag gives an equality test. A datapath uses the block by driving the operands and the code and reading the outputs in the same cycle.

Top module: `alu_ripple`

## Requirements
- R1: Code 0000 gives result = a AND b.
- R2: Code 0001 gives result = a OR b.
- R3: Code 1100 gives result = NOT(a OR b).
- R4: Code 0010 gives result = (a + b) mod 2^32, and carry_o is the carry out of bit 31 of that sum.
- R5: Code 0110 gives result = (a - b) mod 2^32, and carry_o is the carry out of a + ~b + 1, which is 1 exactly when a >= b unsigned.
- R6: For codes 0010 and 0110, ovf_o is 1 exactly when the two effective operands (a, and b or ~b) have the same sign and the result sign differs from it.
- R7: Code 0111 gives result = 1 when a < b as signed two's complement numbers and 0 otherwise, bits 31:1 always 0, and this holds even when a - b overflows.
- R8: zero_o is 1 exactly when all 32 result bits are 0, for every code. After code 0110 it is 1 exactly when a equals b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation: bit 3 invert A, bit 2 negate B, bits 1:0 result select |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | All result bits clear |
| carry_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Signed overflow of the add or subtract |

## Verification
The block holds no state, so a wrong carry, a wrong inversion or a misrouted less bit shows up at the ports in the very evaluation that applies the operands. A carry-chain fault appears only when a carry crosses the faulty slice, so the vectors include long propagate runs such as all-ones plus one and the operand pairs around the sign boundary. A set bit that ignores overflow gives the wrong order only for comparisons that overflow, so those pairs are checked on their own. Random operands then exercise every code.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W   = 32;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned SEL_W   = 2;

  localparam logic [OP_W-1:0] OP_AND = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OP_NOR = 4'b1100;

  localparam logic [SEL_W-1:0] SEL_AND  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_OR   = 2'b01;
  localparam logic [SEL_W-1:0] SEL_SUM  = 2'b10;
  localparam logic [SEL_W-1:0] SEL_LESS = 2'b11;

  typedef struct packed {
    logic ainv;
    logic bneg;
    logic [SEL_W-1:0] sel;
  } op_t;

  typedef struct packed {
    logic res;
    logic sum;
    logic cout;
  } slice_out_t;

  // One-bit slice body shared by the plain and the top slice.
  function automatic slice_out_t slice_eval(input logic a, input logic b,
                                            input logic cin, input op_t op,
                                            input logic less);
    slice_out_t o;
    logic ae, be;
    ae = a ^ op.ainv;
    be = b ^ op.bneg;
    o.sum  = ae ^ be ^ cin;
    o.cout = (ae & be) | (ae & cin) | (be & cin);
    unique case (op.sel)
      SEL_AND: o.res = ae & be;
      SEL_OR:  o.res = ae | be;
      SEL_SUM: o.res = o.sum;
      default: o.res = less;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  op_t  op_i,
  input  logic less_i,
  output logic res_o,
  output logic cout_o
);
  slice_out_t s;

  always_comb begin
    s      = slice_eval(a_i, b_i, cin_i, op_i, less_i);
    res_o  = s.res;
    cout_o = s.cout;
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  op_t  op_i,
  output logic res_o,
  output logic cout_o,
  output logic set_o,
  output logic ovf_o
);
  slice_out_t s;

  always_comb begin
    s      = slice_eval(a_i, b_i, cin_i, op_i, 1'b0);
    res_o  = s.res;
    cout_o = s.cout;
    ovf_o  = cin_i ^ s.cout;
    set_o  = s.sum ^ ovf_o;
  end

  // Overflow only when the effective operand signs agree and the sum sign differs.
  always_comb begin
    if (ovf_o) begin
      assert_ovf_signs_R6: assert (((a_i ^ op_i.ainv) == (b_i ^ op_i.bneg)) &&
                                   (s.sum != (a_i ^ op_i.ainv)))
        else $error("overflow flagged with mixed effective signs");
    end
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  localparam int unsigned HALF = W / 2;

  generate
    if (W == 1) begin : g_leaf
      assign zero_o = ~val_i[0];
    end else begin : g_split
      logic z_lo, z_hi;
      alu_zero_detect #(.W(HALF)) u_lo (.val_i(val_i[HALF-1:0]), .zero_o(z_lo));
      alu_zero_detect #(.W(W-HALF)) u_hi (.val_i(val_i[W-1:HALF]), .zero_o(z_hi));
      assign zero_o = z_lo & z_hi;
    end
  endgenerate
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            carry_o,
  output logic            ovf_o
);
  localparam int unsigned TOP = W - 1;

  op_t          op;
  logic [W:0]   carry;
  logic         set_bit;

  assign op       = op_t'(op_i);
  assign carry[0] = op.bneg;

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      if (i == TOP) begin : g_top
        alu_msb_slice u_msb (
          .a_i(a_i[i]), .b_i(b_i[i]), .cin_i(carry[i]), .op_i(op),
          .res_o(result_o[i]), .cout_o(carry[i+1]),
          .set_o(set_bit), .ovf_o(ovf_o)
        );
      end else if (i == 0) begin : g_lsb
        alu_bit_slice u_bit (
          .a_i(a_i[i]), .b_i(b_i[i]), .cin_i(carry[i]), .op_i(op),
          .less_i(set_bit), .res_o(result_o[i]), .cout_o(carry[i+1])
        );
      end else begin : g_mid
        alu_bit_slice u_bit (
          .a_i(a_i[i]), .b_i(b_i[i]), .cin_i(carry[i]), .op_i(op),
          .less_i(1'b0), .res_o(result_o[i]), .cout_o(carry[i+1])
        );
      end
    end
  endgenerate

  assign carry_o = carry[W];

  alu_zero_detect #(.W(W)) u_zero (.val_i(result_o), .zero_o(zero_o));

  // Port-level checks against arithmetic on the operands.
  always_comb begin
    if (op_i == OP_ADD) begin
      assert_add_R4: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("add mismatch");
    end
    if (op_i == OP_SUB) begin
      assert_sub_R5: assert (result_o == (a_i - b_i) && carry_o == (a_i >= b_i))
        else $error("subtract mismatch");
      assert_eq_R8: assert (zero_o == (a_i == b_i))
        else $error("equality flag mismatch");
    end
    if (op_i == OP_SLT) begin
      assert_slt_R7: assert (result_o == {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("less-than mismatch");
    end
    if (op_i == OP_NOR) begin
      assert_nor_R3: assert (result_o == ~(a_i | b_i))
        else $error("nor mismatch");
    end
  end
endmodule

// File: tb/alu_ripple_bench.sv
module alu_ripple_bench;
  import alu_pkg::*;

  typedef struct {
    logic [31:0] res;
    logic        zero;
    logic        carry;
    logic        ovf;
    logic        chk_flags;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero, carry, ovf;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;

  alu_ripple u_alu_ripple (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(result), .zero_o(zero), .carry_o(carry), .ovf_o(ovf)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic exp_t model(input logic [3:0] o, input logic [31:0] x,
                                 input logic [31:0] y, input string tag);
    exp_t e;
    logic [32:0] s;
    e.tag = tag; e.carry = 0; e.ovf = 0; e.chk_flags = 0;
    case (o)
      OP_AND: e.res = x & y;
      OP_OR:  e.res = x | y;
      OP_NOR: e.res = ~(x | y);
      OP_ADD: begin
        s = {1'b0, x} + {1'b0, y};
        e.res = s[31:0]; e.carry = s[32];
        e.ovf = (x[31] == y[31]) && (s[31] != x[31]);
        e.chk_flags = 1;
      end
      OP_SUB: begin
        e.res = x - y; e.carry = (x >= y);
        e.ovf = (x[31] != y[31]) && (e.res[31] != x[31]);
        e.chk_flags = 1;
      end
      default: e.res = {31'b0, ($signed(x) < $signed(y))};
    endcase
    e.zero = (e.res == 32'b0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input string tag);
    @(posedge clk);
    #1;
    op = o; a = x; b = y;
    q.push_back(model(o, x, y, tag));
  endtask

  // Monitor: compare at the falling edge, half a cycle after the drive.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res || zero !== e.zero ||
          (e.chk_flags && (carry !== e.carry || ovf !== e.ovf))) begin
        errors++;
        $display("FAIL %s op=%b a=%h b=%h: got res=%h z=%b c=%b v=%b, exp res=%h z=%b c=%b v=%b",
                 e.tag, op, a, b, result, zero, carry, ovf, e.res, e.zero, e.carry, e.ovf);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [6];
    ops = '{OP_AND, OP_OR, OP_NOR, OP_ADD, OP_SUB, OP_SLT};
    rst_n = 0; a = 0; b = 0; op = OP_AND;
    repeat (3) @(posedge clk);
    rst_n = 1;
    drive(OP_AND, 32'h0, 32'h0, "R1 idle zero / R8");
    drive(OP_AND, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1 and");
    drive(OP_OR,  32'hF000_0001, 32'h0F00_0100, "R2 or");
    drive(OP_OR,  32'h0, 32'h0, "R2 or zero R8");
    drive(OP_NOR, 32'hAAAA_0000, 32'h5555_0000, "R3 nor");
    drive(OP_NOR, 32'hFFFF_FFFF, 32'h0, "R3 nor all ones R8");
    drive(OP_ADD, 32'h1234_5678, 32'h1111_1111, "R4 add");
    drive(OP_ADD, 32'hFFFF_FFFF, 32'h1, "R4 full carry ripple R8");
    drive(OP_ADD, 32'h7FFF_FFFF, 32'h1, "R6 add pos overflow");
    drive(OP_ADD, 32'h8000_0000, 32'h8000_0000, "R6 add neg overflow");
    drive(OP_ADD, 32'h7FFF_FFFF, 32'h8000_0000, "R6 mixed no overflow");
    drive(OP_SUB, 32'h0000_0005, 32'h0000_0007, "R5 sub borrow");
    drive(OP_SUB, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R5 sub equal R8");
    drive(OP_SUB, 32'h8000_0000, 32'h1, "R6 sub overflow");
    drive(OP_SUB, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R6 sub overflow pos");
    drive(OP_SLT, 32'hFFFF_FFFB, 32'h3, "R7 neg less");
    drive(OP_SLT, 32'h3, 32'hFFFF_FFFB, "R7 pos not less");
    drive(OP_SLT, 32'h8000_0000, 32'h1, "R7 overflowing less");
    drive(OP_SLT, 32'h7FFF_FFFF, 32'h8000_0000, "R7 overflowing not less");
    drive(OP_SLT, 32'h42, 32'h42, "R7 equal");
    for (int i = 0; i < 120; i++) begin
      drive(ops[i % 6], $urandom, $urandom, "R1-random mix R4 R5 R7");
    end
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule